// File: doc/BRIEF.md
# Address Translation Unit with Page-Table Refill

This block turns a 28-bit virtual address into a physical address. A small translation buffer holds recent page translations. It sits in front of an on-chip page table, which software loads through a dedicated write port. Each accepted lookup ends in one of three ways:

- The buffer already holds the page, and the block answers in one cycle.
- The buffer misses but the page table has a valid entry. The translation is installed in the buffer and returned two cycles after the request.
- The page-table entry is invalid or lies outside the table. The block reports a fault two cycles after the request and leaves the buffer untouched.

Parameters set the page-offset width (12 bits for 4 KB pages, 14 bits for 16 KB pages) and the number of ways per set. The number of ways selects the organisation: equal to the entry count gives fully associative, 2 gives two-way, and 1 gives direct-mapped. Replacement is exact least-recently-used within each set. While a miss is being resolved, a busy flag tells the requester that new requests are ignored. A page-table write also removes any buffered copy of the page it overwrites, so the buffer never holds a translation without a valid table entry behind it.

Top module: `vtrans_unit`

## Requirements
- R1: The physical address is the physical page number placed above the unchanged low OFF_W bits of the virtual address. The virtual page number is bits [VA_W-1:OFF_W].
- R2: A request accepted while busy is low that hits in the buffer gives rsp_valid one cycle later, with rsp_kind = 1 and the buffered physical page number.
- R3: A request that misses, and whose page-table entry is valid, gives rsp_valid two cycles later with rsp_kind = 2. The translation is installed, so a repeat request for the same page hits.
- R4: A miss whose page-table entry is invalid, or whose page number is 2**PT_W or above, gives rsp_kind = 3 and rsp_pa = 0 two cycles later. The buffer contents and their recency order stay unchanged.
- R5: The set is the page number modulo ENTRIES/WAYS. WAYS = ENTRIES gives one fully associative set, and WAYS = 1 gives a direct-mapped buffer.
- R6: A refill takes the lowest-numbered invalid way of the set, or the least-recently-used way if every way is valid. Every hit and every refill makes its way the most recently used.
- R7: busy is high exactly in the cycle after a miss is accepted. A request presented while busy is high is ignored and gets no response.
- R8: After synchronous reset, all entries are invalid, rsp_valid and busy are low, and way 0 is the oldest in every set, then way 1, and so on.
- R9: A page-table write at index i sets entry i's valid bit and page number, and invalidates any buffered translation for page i.
- R10: rsp_valid pulses for exactly one cycle per accepted request and is low at all other times. rsp_kind is 0 when no response is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | VA_W | Virtual address of the request |
| busy | output | 1 | Miss being resolved; requests ignored |
| rsp_valid | output | 1 | Response strobe |
| rsp_pa | output | PPN_W+OFF_W | Physical address (0 on fault) |
| rsp_kind | output | 2 | 1 buffer hit, 2 table hit, 3 fault, 0 none |
| pt_we | input | 1 | Page-table write strobe |
| pt_idx | input | PT_W | Page-table index written |
| pt_valid | input | 1 | Valid bit written |
| pt_ppn | input | PPN_W | Physical page number written |

## Verification
The assertions assume that pt_we is never raised while busy is high or in the same cycle as req_valid. Under that assumption a table write cannot overlap a refill or a lookup of the same set. The benches raise a table write only in cycles when their own model has no miss outstanding, and they drop req_valid in those cycles. Requests are otherwise presented freely, including while busy is high, to exercise R7. Three configurations are run: fully associative with 4 KB pages, two-way with 16 KB pages, and direct-mapped with 4 KB pages.

// File: rtl/vt_pkg.sv
package vt_pkg;
  typedef enum logic [1:0] {
    VT_NONE  = 2'd0,
    VT_TLB   = 2'd1,
    VT_WALK  = 2'd2,
    VT_FAULT = 2'd3
  } vt_kind_e;
endpackage

// File: rtl/vt_ptable.sv
module vt_ptable #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 2 ** IDX_W;
  logic [DATA_W-1:0] mem [DEPTH];

  // single write port, registered read: block-RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[wr_idx] <= wr_data;
    if (rd_en) rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/vt_lru_set.sv
module vt_lru_set #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [WAYS-1:0]  way_valid,
  output logic [WAY_W-1:0] victim
);
  logic [WAY_W-1:0] age [WAYS];

  // age 0 = most recent; ages stay a permutation of 0..WAYS-1
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < WAYS; w++) age[w] <= WAY_W'(WAYS - 1 - w);
    end else if (touch) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way) age[w] <= '0;
        else if (age[w] < age[touch_way]) age[w] <= age[w] + 1'b1;
      end
    end
  end

  always_comb begin
    victim = '0;
    for (int w = 0; w < WAYS; w++)
      if (age[w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
    for (int w = WAYS - 1; w >= 0; w--)
      if (!way_valid[w]) victim = WAY_W'(w);
  end

  // R6: a way just made most recent is not the next victim of a full set
  a_r6_mru_not_victim: assert property (@(posedge clk) disable iff (rst)
    (touch && WAYS > 1) |=> (!(&way_valid) || victim != $past(touch_way)));
endmodule

// File: rtl/vtrans_unit.sv
module vtrans_unit
  import vt_pkg::*;
#(
  parameter int VA_W    = 28,
  parameter int OFF_W   = 12,
  parameter int PPN_W   = 8,
  parameter int ENTRIES = 4,
  parameter int WAYS    = 4,
  parameter int PT_W    = 4,
  localparam int PA_W   = PPN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_va,
  output logic              busy,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [1:0]        rsp_kind,
  input  logic              pt_we,
  input  logic [PT_W-1:0]   pt_idx,
  input  logic              pt_valid,
  input  logic [PPN_W-1:0]  pt_ppn
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int SETS  = ENTRIES / WAYS;
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  function automatic logic [SET_W-1:0] set_of(input logic [VPN_W-1:0] vpn);
    return (SETS > 1) ? vpn[SET_W-1:0] : '0;
  endfunction

  // translation entries, index = set*WAYS + way
  logic [ENTRIES-1:0] e_valid;
  logic [VPN_W-1:0]   e_vpn [ENTRIES];
  logic [PPN_W-1:0]   e_ppn [ENTRIES];

  // request-side lookup
  logic [VPN_W-1:0] req_vpn;
  logic [SET_W-1:0] req_set;
  logic [WAYS-1:0]  hit_vec;
  logic [WAY_W-1:0] hit_way;
  logic [PPN_W-1:0] hit_ppn;
  logic             hit, accept, req_inr;

  assign req_vpn = req_va[VA_W-1:OFF_W];
  assign req_set = set_of(req_vpn);
  assign accept  = req_valid && !busy;
  assign req_inr = (req_vpn >> PT_W) == '0;

  always_comb begin
    hit_way = '0;
    hit_ppn = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = e_valid[int'(req_set) * WAYS + w] &&
                   (e_vpn[int'(req_set) * WAYS + w] == req_vpn);
      if (hit_vec[w]) begin
        hit_way = WAY_W'(w);
        hit_ppn = e_ppn[int'(req_set) * WAYS + w];
      end
    end
  end
  assign hit = |hit_vec;

  // pending miss
  logic             pend;
  logic [VPN_W-1:0] p_vpn;
  logic [SET_W-1:0] p_set;
  logic [OFF_W-1:0] p_off;
  logic             p_inr;
  logic [PPN_W:0]   pt_q;
  logic             walk_ok;

  vt_ptable #(.IDX_W(PT_W), .DATA_W(PPN_W + 1)) i_ptable (
    .clk     (clk),
    .we      (pt_we),
    .wr_idx  (pt_idx),
    .wr_data ({pt_valid, pt_ppn}),
    .rd_en   (accept && !hit),
    .rd_idx  (req_vpn[PT_W-1:0]),
    .rd_data (pt_q)
  );

  assign walk_ok = pend && p_inr && pt_q[PPN_W];
  assign busy    = pend;

  // replacement state, one instance per set
  logic [WAY_W-1:0] vic_all [SETS];
  logic [WAY_W-1:0] victim;
  logic [WAY_W-1:0] touch_way;
  assign victim    = vic_all[p_set];
  assign touch_way = pend ? victim : hit_way;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    vt_lru_set #(.WAYS(WAYS), .WAY_W(WAY_W)) i_lru (
      .clk       (clk),
      .rst       (rst),
      .touch     ((accept && hit && req_set == SET_W'(s)) ||
                  (walk_ok && p_set == SET_W'(s))),
      .touch_way (touch_way),
      .way_valid (e_valid[s*WAYS +: WAYS]),
      .victim    (vic_all[s])
    );
  end

  logic [SET_W-1:0] wr_set;
  assign wr_set = set_of(VPN_W'(pt_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_kind  <= VT_NONE;
      rsp_pa    <= '0;
      e_valid   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_kind  <= VT_NONE;
      if (pend) begin
        pend      <= 1'b0;
        rsp_valid <= 1'b1;
        if (walk_ok) begin
          rsp_kind <= VT_WALK;
          rsp_pa   <= {pt_q[PPN_W-1:0], p_off};
          e_valid[int'(p_set) * WAYS + int'(victim)] <= 1'b1;
        end else begin
          rsp_kind <= VT_FAULT;
          rsp_pa   <= '0;
        end
      end else if (accept && hit) begin
        rsp_valid <= 1'b1;
        rsp_kind  <= VT_TLB;
        rsp_pa    <= {hit_ppn, req_va[OFF_W-1:0]};
      end else if (accept) begin
        pend <= 1'b1;
      end
      if (pt_we) begin
        for (int w = 0; w < WAYS; w++)
          if (e_vpn[int'(wr_set) * WAYS + w] == VPN_W'(pt_idx))
            e_valid[int'(wr_set) * WAYS + w] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept && !hit) begin
      p_vpn <= req_vpn;
      p_set <= req_set;
      p_off <= req_va[OFF_W-1:0];
      p_inr <= req_inr;
    end
    if (walk_ok) begin
      e_vpn[int'(p_set) * WAYS + int'(victim)] <= p_vpn;
      e_ppn[int'(p_set) * WAYS + int'(victim)] <= pt_q[PPN_W-1:0];
    end
  end

  // R2: a buffer hit answers on the next cycle
  a_r2_hit_next_cycle: assert property (@(posedge clk) disable iff (rst)
    (accept && hit) |=> (rsp_valid && rsp_kind == VT_TLB));
  // R7: a miss raises busy, then answers from the table
  a_r7_miss_busy_then_rsp: assert property (@(posedge clk) disable iff (rst)
    (accept && !hit) |=> (busy && !rsp_valid) ##1 (rsp_valid && rsp_kind != VT_TLB));
  // R5: at most one way of the indexed set matches
  a_r5_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
  // R4: a fault leaves the buffer untouched
  a_r4_fault_keeps_entries: assert property (@(posedge clk) disable iff (rst)
    (pend && !walk_ok) |=> $stable(e_valid));
  // R9: table writes only while idle and without a request
  a_r9_write_when_idle: assert property (@(posedge clk) disable iff (rst)
    pt_we |-> (!busy && !req_valid));
endmodule

// File: tb/test_vtrans_unit.sv
module vt_bench_core #(
  parameter int WAYS  = 4,
  parameter int OFF_W = 12,
  parameter int SEED  = 1
) (
  input  logic clk,
  output logic done,
  output int   nchk,
  output int   nbad
);
  localparam int VA_W = 28, PPN_W = 8, ENTRIES = 4, PT_W = 4;
  localparam int SETS = ENTRIES / WAYS;
  localparam int PT_N = 2 ** PT_W;
  localparam int PA_W = PPN_W + OFF_W;

  logic              rst, req_valid, pt_we, pt_valid;
  logic [VA_W-1:0]   req_va;
  logic [PT_W-1:0]   pt_idx;
  logic [PPN_W-1:0]  pt_ppn;
  logic              busy, rsp_valid;
  logic [PA_W-1:0]   rsp_pa;
  logic [1:0]        rsp_kind;

  vtrans_unit #(.VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .ENTRIES(ENTRIES),
                .WAYS(WAYS), .PT_W(PT_W)) i_vtrans_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_kind(rsp_kind),
    .pt_we(pt_we), .pt_idx(pt_idx), .pt_valid(pt_valid), .pt_ppn(pt_ppn)
  );

  // behavioural model
  int mv [ENTRIES];
  int mvpn [ENTRIES];
  int mppn [ENTRIES];
  int ord [SETS][$];   // per set: front = least recent
  int ptv [PT_N];
  int ptp [PT_N];
  int m_pend, p_vpn, p_off;
  int e_valid, e_kind, e_pa;

  function automatic void touch(int s, int w);
    foreach (ord[s][i]) if (ord[s][i] == w) begin ord[s].delete(i); break; end
    ord[s].push_back(w);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++) mv[e] = 0;
      for (int s = 0; s < SETS; s++) begin
        ord[s].delete();
        for (int w = 0; w < WAYS; w++) ord[s].push_back(w);
      end
      m_pend = 0; e_valid = 0; e_kind = 0; e_pa = 0;
    end else begin
      e_valid = 0; e_kind = 0;
      if (m_pend != 0) begin
        int s;
        m_pend = 0; e_valid = 1;
        s = p_vpn % SETS;
        if (p_vpn < PT_N && ptv[p_vpn] != 0) begin
          int vw;
          e_kind = 2;
          e_pa = ptp[p_vpn] * (2 ** OFF_W) + p_off;
          vw = -1;
          for (int w = 0; w < WAYS; w++) if (vw < 0 && mv[s*WAYS+w] == 0) vw = w;
          if (vw < 0) vw = ord[s][0];
          mv[s*WAYS+vw] = 1; mvpn[s*WAYS+vw] = p_vpn; mppn[s*WAYS+vw] = ptp[p_vpn];
          touch(s, vw);
        end else begin
          e_kind = 3; e_pa = 0;
        end
      end else if (req_valid) begin
        int vpn, s, hw;
        vpn = int'(req_va >> OFF_W);
        s = vpn % SETS;
        hw = -1;
        for (int w = 0; w < WAYS; w++)
          if (mv[s*WAYS+w] != 0 && mvpn[s*WAYS+w] == vpn) hw = w;
        if (hw >= 0) begin
          e_valid = 1; e_kind = 1;
          e_pa = mppn[s*WAYS+hw] * (2 ** OFF_W) + int'(req_va) % (2 ** OFF_W);
          touch(s, hw);
        end else begin
          m_pend = 1; p_vpn = vpn; p_off = int'(req_va) % (2 ** OFF_W);
        end
      end
      if (pt_we) begin
        int s;
        ptv[pt_idx] = pt_valid ? 1 : 0;
        ptp[pt_idx] = int'(pt_ppn);
        s = int'(pt_idx) % SETS;
        for (int w = 0; w < WAYS; w++)
          if (mvpn[s*WAYS+w] == int'(pt_idx)) mv[s*WAYS+w] = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s ways=%0d off=%0d: actual=%0h expected=%0h", req, WAYS, OFF_W, act, exp);
    end
  endtask

  task automatic compare();
    string tag;
    check(rsp_valid == (e_valid != 0), "R10 response strobe", int'(rsp_valid), e_valid);
    check(busy == (m_pend != 0), "R7 busy", int'(busy), m_pend);
    if (e_valid != 0) begin
      case (e_kind)
        1: tag = "R2 R5 R6 kind";
        2: tag = "R3 R5 R6 R9 kind";
        default: tag = "R4 R9 kind";
      endcase
      check(int'(rsp_kind) == e_kind, tag, int'(rsp_kind), e_kind);
      check(int'(rsp_pa) == e_pa, "R1 physical address", int'(rsp_pa), e_pa);
    end else begin
      check(rsp_kind == 2'd0, "R10 idle kind", int'(rsp_kind), 0);
    end
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(SEED);
    done = 0; nchk = 0; nbad = 0;
    m_pend = 0; e_valid = 0;
    rst = 1; req_valid = 0; req_va = '0; pt_we = 0; pt_idx = '0; pt_valid = 0; pt_ppn = '0;
    repeat (3) @(negedge clk);
    check(!rsp_valid && !busy && rsp_kind == 2'd0, "R8 reset state",
          int'({rsp_valid, busy, rsp_kind}), 0);
    rst = 0;
    for (int c = 0; c < 900; c++) begin
      @(negedge clk);
      compare();
      pt_we = 0; req_valid = 0;
      if (c < PT_N) begin
        pt_we = 1; pt_idx = PT_W'(c);
        pt_valid = !(c == 0 || c == 4 || c == 5 || (c >= 9 && c <= 14));
        pt_ppn = PPN_W'(8'h10 + c);
      end else begin
        int r;
        r = $urandom_range(0, 24);
        if (r == 0 && m_pend == 0) begin
          pt_we = 1; pt_idx = PT_W'($urandom_range(0, PT_N - 1));
          pt_valid = $urandom_range(0, 3) != 0;
          pt_ppn = PPN_W'($urandom_range(0, 255));
        end else if (r < 19) begin
          int vpn;
          vpn = $urandom_range(0, PT_N + 3);
          req_valid = 1;
          req_va = VA_W'(vpn * (2 ** OFF_W) + $urandom_range(0, 2 ** OFF_W - 1));
        end
      end
    end
    @(negedge clk);
    compare();
    done = 1;
  end
endmodule

module test_vtrans_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic d0, d1, d2;
  int   n0, n1, n2, b0, b1, b2;

  vt_bench_core #(.WAYS(4), .OFF_W(12), .SEED(11)) i_full (.clk(clk), .done(d0), .nchk(n0), .nbad(b0));
  vt_bench_core #(.WAYS(2), .OFF_W(14), .SEED(23)) i_two  (.clk(clk), .done(d1), .nchk(n1), .nbad(b1));
  vt_bench_core #(.WAYS(1), .OFF_W(12), .SEED(37)) i_dm   (.clk(clk), .done(d2), .nchk(n2), .nbad(b2));

  initial begin
    int total, bad, cyc;
    cyc = 0; bad = 0;
    while (!(d0 === 1'b1 && d1 === 1'b1 && d2 === 1'b1) && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    total = n0 + n1 + n2;
    bad   = b0 + b1 + b2;
    if (cyc >= WATCHDOG) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WATCHDOG);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule